// File: doc/BRIEF.md
# Seven-Segment Decoder Chain with Leading-Zero Blanking

This block turns a row of BCD digits into segment drive for a common-anode seven-segment display, one digit cell per position. The segment outputs are active low, so a 0 bit lights a segment. A shared lamp-test control lights every segment of every digit so the display can be checked for dead segments.

Leading-zero suppression works through a blanking chain that runs from the most significant digit down to the least significant one. The chain's entry is the `blank_in_n` port. While the chain is active, a digit that holds zero goes dark and passes the blanking on to the next lower position. The first non-zero digit ends the suppression for itself and for every digit below it. The blanking state that leaves the lowest digit appears on `blank_out_n`. A further instance can continue the chain from there.

The number of digits is set by a parameter. The segment outputs and the chain exit are registered, with a synchronous active-low reset. The outputs therefore show the inputs that were sampled at the previous rising clock edge.

Top module: `segdec_chain`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are all segments off (`seg_n` all ones) and `blank_out_n` = 1. Reset takes priority over lamp test.
- R2: Each digit's 7-bit field of `seg_n` is active low, ordered a (bit 6) down to g (bit 0). Codes 0–9 give these active-high patterns: 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex). The field driven is the bitwise inverse of the pattern.
- R3: A digit holding a code from 10 to 15 drives all segments off (field = 7F). Such a digit ends blanking for itself and for all lower digits.
- R4: When `lamp_test_n` is 0, every field is 0000000 (all segments on), whatever the data and blanking inputs. `blank_out_n` is then 1.
- R5: A digit whose incoming blank is 0 and whose code is 0 shows all segments off, and its outgoing blank is 0.
- R6: A digit whose incoming blank is 0 but whose code is not 0 shows its normal pattern. Its outgoing blank is 1, so lower zero digits display "0".
- R7: A digit whose incoming blank is 1 shows a zero code as the normal "0" pattern.
- R8: Digit DIGITS-1 (bits 4*DIGITS-1 down to 4*DIGITS-4 of `digits_bcd`, and the top 7 bits of `seg_n`) is the most significant digit and takes `blank_in_n`. Each lower digit takes the outgoing blank of the digit above it. `blank_out_n` is the outgoing blank of digit 0.
- R9: Outputs change only at a rising clock edge, one cycle after the inputs were sampled. A change of input between edges leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lamp_test_n | input | 1 | Lamp test, active low: all segments on |
| blank_in_n | input | 1 | Blanking chain entry at the most significant digit, active low |
| digits_bcd | input | 4*DIGITS | BCD digits; digit d occupies bits 4d+3..4d |
| seg_n | output | 7*DIGITS | Active-low segments; digit d occupies bits 7d+6..7d, a at the top |
| blank_out_n | output | 1 | Blanking chain exit from digit 0, active low |

## Verification
The bench builds the chain with DIGITS = 3. This keeps the 4096 combinations of the three digit codes small enough to sweep completely under all four settings of lamp test and chain entry. That sweep reaches every way blanking can stop part-way down the chain: at the top, in the middle, at an invalid code, or never. It also covers the invalid codes at every position and lamp test overriding a fully blanked row. Directed cases pin down the reset priority over lamp test, the mid-chain restart of zeros and the one-cycle output timing.

// File: rtl/segdec_pkg.sv
// Package: segdec_pkg
// Shared widths, types and constant patterns for the seven-segment
// decoder chain. Assumes segment order a..g from MSB to LSB.
package segdec_pkg;
    localparam int BCD_W = 4;
    localparam int SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Active-low drive levels for the whole digit.
    localparam seg_t SEG_ALL_OFF_N = '1;
    localparam seg_t SEG_ALL_ON_N  = '0;

    // Highest code that is a valid decimal digit.
    localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/segdec_rom.sv
// Module: segdec_rom
// Looks up the active-high segment pattern for one BCD code.
// Assumes: purely combinational; codes above 9 return an empty pattern.
module segdec_rom
    import segdec_pkg::*;
(
    input  bcd_t code_i,
    output seg_t pat_o,
    output logic valid_o
);
    // Pattern lookup, segment a in bit 6 down to g in bit 0.
    always_comb begin
        unique case (code_i)
            4'd0:    pat_o = 7'b1111110;
            4'd1:    pat_o = 7'b0110000;
            4'd2:    pat_o = 7'b1101101;
            4'd3:    pat_o = 7'b1111001;
            4'd4:    pat_o = 7'b0110011;
            4'd5:    pat_o = 7'b1011011;
            4'd6:    pat_o = 7'b1011111;
            4'd7:    pat_o = 7'b1110000;
            4'd8:    pat_o = 7'b1111111;
            4'd9:    pat_o = 7'b1111011;
            default: pat_o = 7'b0000000;
        endcase
    end

    // Marks codes that belong to a decimal digit.
    assign valid_o = (code_i <= BCD_MAX);
endmodule

// File: rtl/segdec_cell.sv
// Module: segdec_cell
// One digit position: decodes the code, applies lamp test and the
// blanking chain, and produces the active-low segment field.
// Assumes: combinational; the caller registers the outputs.
module segdec_cell
    import segdec_pkg::*;
(
    input  bcd_t code_i,
    input  logic lamp_n_i,
    input  logic rb_in_n_i,
    output seg_t seg_n_o,
    output logic rb_out_n_o
);
    seg_t pat;
    logic valid;
    logic is_zero;
    logic blank;

    segdec_rom u_rom (
        .code_i  (code_i),
        .pat_o   (pat),
        .valid_o (valid)
    );

    // Zero detection feeds the blanking decision.
    assign is_zero = (code_i == '0);

    // Blanking needs an active chain, a zero digit and no lamp test.
    assign blank = !rb_in_n_i && is_zero && lamp_n_i;

    // The chain continues only through a blanked digit.
    assign rb_out_n_o = !blank;

    // Segment drive priority: lamp test, then blanking, then decode.
    always_comb begin
        if (!lamp_n_i)
            seg_n_o = SEG_ALL_ON_N;
        else if (blank || !valid)
            seg_n_o = SEG_ALL_OFF_N;
        else
            seg_n_o = ~pat;
    end
endmodule

// File: rtl/segdec_chain.sv
// Module: segdec_chain
// Row of DIGITS decoder cells joined by a leading-zero blanking chain
// that runs from the most significant digit (DIGITS-1) to digit 0.
// Assumes: synchronous active-low reset; outputs registered one cycle.
module segdec_chain
    import segdec_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lamp_test_n,
    input  logic                  blank_in_n,
    input  logic [BCD_W*DIGITS-1:0] digits_bcd,
    output logic [SEG_W*DIGITS-1:0] seg_n,
    output logic                  blank_out_n
);
    localparam int SEG_BITS = SEG_W * DIGITS;

    logic [DIGITS:0]       rb_n;
    logic [SEG_BITS-1:0]   seg_comb;

    // Chain entry sits above the most significant digit.
    assign rb_n[DIGITS] = blank_in_n;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        segdec_cell u_cell (
            .code_i     (digits_bcd[d*BCD_W +: BCD_W]),
            .lamp_n_i   (lamp_test_n),
            .rb_in_n_i  (rb_n[d+1]),
            .seg_n_o    (seg_comb[d*SEG_W +: SEG_W]),
            .rb_out_n_o (rb_n[d])
        );

        // R3: an invalid code leaves the digit dark unless lamp test is on.
        assert_bad_code_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(lamp_test_n) &&
             ($past(digits_bcd[d*BCD_W +: BCD_W]) > BCD_MAX))
            |-> (seg_n[d*SEG_W +: SEG_W] == SEG_ALL_OFF_N));
    end

    // Output register: segments and chain exit, cleared to dark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_n       <= {SEG_BITS{1'b1}};
            blank_out_n <= 1'b1;
        end else begin
            seg_n       <= seg_comb;
            blank_out_n <= rb_n[0];
        end
    end

    // R1: a reset cycle leaves every segment off and the chain exit high.
    assert_reset_dark_R1: assert property (@(posedge clk)
        !rst_n |=> (seg_n == {SEG_BITS{1'b1}} && blank_out_n));

    // R4: lamp test lights everything and stops the chain.
    assert_lamp_all_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lamp_test_n))
        |-> (seg_n == '0 && blank_out_n));

    // R5: an active chain exit means every digit above it was blanked.
    assert_exit_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_out_n |-> (seg_n == {SEG_BITS{1'b1}}));

    // R8: the chain can only be active at the exit if it entered active.
    assert_chain_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !blank_out_n) |-> !$past(blank_in_n));
endmodule

// File: tb/segdec_chain_tb.sv
`timescale 1ns/1ps
module segdec_chain_tb_top;
    localparam int DIGITS = 3;
    localparam int DW = 4 * DIGITS;
    localparam int SW = 7 * DIGITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lamp_test_n = 1'b0;
    logic blank_in_n = 1'b0;
    logic [DW-1:0] digits_bcd = '0;
    logic [SW-1:0] seg_n;
    logic blank_out_n;

    int errors = 0;
    int checks = 0;

    logic [6:0]    pat [10];
    logic [SW-1:0] exp_seg;
    logic          exp_bo;
    string         exp_tag [DIGITS];

    always #2 clk = ~clk;

    segdec_chain #(.DIGITS(DIGITS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .lamp_test_n (lamp_test_n),
        .blank_in_n  (blank_in_n),
        .digits_bcd  (digits_bcd),
        .seg_n       (seg_n),
        .blank_out_n (blank_out_n)
    );

    // Behavioural reference: walk from the top digit down.
    task automatic model(input logic [DW-1:0] v, input logic lt_n, input logic bin_n);
        bit sup = !bin_n;
        for (int d = DIGITS - 1; d >= 0; d--) begin
            int val = int'(v[d*4 +: 4]);
            if (!lt_n) begin
                exp_seg[d*7 +: 7] = 7'h00; exp_tag[d] = "R4"; sup = 0;
            end else if (val > 9) begin
                exp_seg[d*7 +: 7] = 7'h7F; exp_tag[d] = "R3"; sup = 0;
            end else if (val == 0 && sup) begin
                exp_seg[d*7 +: 7] = 7'h7F; exp_tag[d] = "R5";
            end else begin
                exp_seg[d*7 +: 7] = ~pat[val];
                exp_tag[d] = (val == 0) ? "R7" : "R2";
                sup = 0;
            end
        end
        exp_bo = !sup;
    endtask

    task automatic check_raw(input string tag, input logic [SW-1:0] es, input logic eb);
        checks++;
        if (seg_n !== es || blank_out_n !== eb) begin
            errors++;
            $display("FAIL %s: seg_n=%h blank_out_n=%b expected %h %b", tag, seg_n, blank_out_n, es, eb);
        end
    endtask

    task automatic compare();
        for (int d = 0; d < DIGITS; d++) begin
            checks++;
            if (seg_n[d*7 +: 7] !== exp_seg[d*7 +: 7]) begin
                errors++;
                $display("FAIL %s digit %0d: seg=%b expected %b", exp_tag[d], d,
                         seg_n[d*7 +: 7], exp_seg[d*7 +: 7]);
            end
        end
        checks++;
        if (blank_out_n !== exp_bo) begin
            errors++;
            $display("FAIL R8 chain exit: blank_out_n=%b expected %b", blank_out_n, exp_bo);
        end
    endtask

    // Drive at a falling edge, confirm no early change (R9), compare after the edge.
    task automatic step(input logic [DW-1:0] v, input logic lt_n, input logic bin_n);
        logic [SW-1:0] old_seg = exp_seg;
        logic          old_bo  = exp_bo;
        digits_bcd = v; lamp_test_n = lt_n; blank_in_n = bin_n;
        #1;
        check_raw("R9", old_seg, old_bo);
        model(v, lt_n, bin_n);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pat[0] = 7'h7E; pat[1] = 7'h30; pat[2] = 7'h6D; pat[3] = 7'h79; pat[4] = 7'h33;
        pat[5] = 7'h5B; pat[6] = 7'h5F; pat[7] = 7'h70; pat[8] = 7'h7F; pat[9] = 7'h7B;

        // R1: reset held with lamp test asserted still gives a dark row.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_raw("R1", {SW{1'b1}}, 1'b1);
        exp_seg = {SW{1'b1}}; exp_bo = 1'b1;
        rst_n = 1'b1;

        // R6: chain active, digits 0,5,0 -> dark, "5", "0".
        step(12'h050, 1'b1, 1'b0);
        check_raw("R6", {7'h7F, 7'h24, 7'h01}, 1'b1);
        // R7: chain inactive, all zeros shown.
        step(12'h000, 1'b1, 1'b1);
        check_raw("R7", {7'h01, 7'h01, 7'h01}, 1'b1);
        // R5: chain active, all zeros -> dark row and active exit.
        step(12'h000, 1'b1, 1'b0);
        check_raw("R5", {SW{1'b1}}, 1'b0);
        // R4: lamp test over a fully blanked row.
        step(12'h000, 1'b0, 1'b0);
        check_raw("R4", '0, 1'b1);
        // R3: invalid code in the top digit stops blanking below it.
        step(12'hA00, 1'b1, 1'b0);
        check_raw("R3", {7'h7F, 7'h01, 7'h01}, 1'b1);

        // R2/R3/R4/R5/R8 exhaustive sweep across all control settings.
        for (int ctl = 0; ctl < 4; ctl++) begin
            for (int v = 0; v < (1 << DW); v++) begin
                step(DW'(v), ctl[1], ctl[0]);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule